// File: doc/BRIEF.md
# Serial Register Slave with Status Preamble

This block lets an external SPI master read and write a small register file. The block runs on the chip's system clock. It brings the serial chip select, serial clock and input data in through synchronizers, and it finds the serial clock edges by comparing successive samples. Each transaction starts with a header. The first bit selects read or write. The second bit selects the address format: a compact one-byte header, or a two-byte header whose second byte is padding. Data bytes follow the header. In a burst they step through consecutive addresses, and the address wraps at the top of the address space.

The register file sits outside the block. On its side the block has a simple port: an address, a one-cycle write strobe with data, and a one-cycle read strobe. Read data must come back combinationally in the same cycle as the read strobe. A configuration input turns on a status preamble. With it on, six live status bits are shifted out while the header comes in, and the output is then released. A second configuration input selects 3-wire operation. In that mode read data leaves on the shared data line instead of the output line. Both configuration inputs are sampled when a transaction starts.

The serial clock must stay high and low for at least four system clock cycles each. The status width must be smaller than the one-byte header length.

Top module: `spi_regslave`

## Requirements
- R1: A transaction begins when chip select goes low. Header bit 1 is the direction (1 = read, 0 = write). When header bit 2 is 1, bits 3 to 8 carry the address MSB first and data starts at bit 9.
- R2: When header bit 2 is 0, the address still arrives in bits 3 to 8. Bits 9 to 16 are ignored padding, and data starts at bit 17. The output stays undriven during the padding.
- R3: Input bits are taken on rising serial clock edges. Output bits change on falling edges. Every byte is sent MSB first.
- R4: Once all 8 bits of a write data byte have arrived, `reg_we_o` is high for exactly one cycle, carrying that byte and its address. No read strobe is issued in the same cycle.
- R5: Each further byte of a burst uses the next address. Address 63 is followed by address 0.
- R6: `reg_re_o` pulses for one cycle when the last header bit is taken, and again after each completed read byte, with the next address. The captured byte is valid on the output before the first rising edge of its data bits.
- R7: When the status preamble is on and 3-wire mode is off, every transaction drives `status_i[5]` from the start. The next falling edges give `status_i[4]` down to `status_i[0]`, so the bits are taken at rising edges 1 to 6. The output is released at the falling edge after rising edge 6. Bit 5 = interrupt pending, 4 = FIFO level reached, 3 = FIFO full, 2 = FIFO empty, 1 = new sample, 0 = wake.
- R8: In 3-wire mode, read data leaves on `sio_o`/`sio_oe_o`. `spi_miso_oe_o` is never asserted, and the status preamble is suppressed.
- R9: Both output enables are low within SYNC_STAGES+1 cycles after chip select goes high, during write data, and during the header whenever no status preamble is active.
- R10: A data byte still incomplete when chip select rises causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n_i | input | 1 | Serial chip select, active low |
| spi_clk_i | input | 1 | Serial clock from the master |
| spi_mosi_i | input | 1 | Serial data from the master (shared line in 3-wire mode) |
| spi_miso_o | output | 1 | Serial output data |
| spi_miso_oe_o | output | 1 | Output enable for `spi_miso_o` |
| sio_o | output | 1 | Read data for the shared line in 3-wire mode |
| sio_oe_o | output | 1 | Output enable for the shared line |
| cfg_3wire_i | input | 1 | 1 selects 3-wire operation |
| cfg_status_i | input | 1 | 1 enables the status preamble |
| status_i | input | STAT_W | Live status bits, bit order as in R7 |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | DATA_W | Register read data, valid in the read strobe cycle |

## Verification
The bench builds the block with its default parameters: a 6-bit address, 8-bit data, 6 status bits and two synchronizer stages. With the 64-entry space, a three-byte burst starting at address 62 crosses the wrap point. With two synchronizer stages, the output release after chip select rises has a fixed three-cycle latency, and the bench checks against it on every clock. The serial clock half period of eight system cycles leaves room to see each output bit settle before the rising edge where the master takes it.

// File: rtl/spi_rs_pkg.sv
// Package: shared encodings for the serial register slave.
// Assumes: header bit 1 selects the direction and header bit 2 selects the address format.
package spi_rs_pkg;
    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } xfer_dir_e;

    typedef enum logic {
        ADDR_LONG  = 1'b0,
        ADDR_SHORT = 1'b1
    } addr_fmt_e;
endpackage

// File: rtl/spi_rs_sync.sv
// Module: multi-stage synchronizer for one asynchronous pin.
// Assumes: the pin is slow next to clk; RST_VAL is the pin's idle level.
module spi_rs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first stage captures the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= d_i;
            end
        end else begin : g_next
            // Purpose: later stages settle the sample.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_rs_frame.sv
// Module: header decoding, receive shifting and register port strobes.
// Assumes: rising-edge events are single-cycle pulses, at least four cycles apart.
module spi_rs_frame import spi_rs_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              clk_rise,
    input  logic              mosi_s,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    output logic [CNT_W-1:0]  hdr_cnt_o,
    output logic              in_data_o,
    output logic              is_read_o
);
    localparam int HDR_SHORT = 2 + ADDR_W;
    localparam int HDR_LONG  = HDR_SHORT + DATA_W;
    localparam int BIT_W     = $clog2(DATA_W);

    xfer_dir_e         dir_q;
    addr_fmt_e         fmt_q;
    logic [CNT_W-1:0]  hdr_cnt, hdr_next, hdr_len;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-2:0] rx_sr;
    logic              in_data;

    assign hdr_next = hdr_cnt + 1'b1;
    assign hdr_len  = (fmt_q == ADDR_SHORT) ? CNT_W'(HDR_SHORT) : CNT_W'(HDR_LONG);

    // Purpose: walk the header, collect data bytes and issue register strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_WRITE; fmt_q <= ADDR_LONG; hdr_cnt <= '0; bit_idx <= '0;
            rx_sr <= '0; in_data <= 1'b0; reg_addr_o <= '0; reg_wdata_o <= '0;
            reg_we_o <= 1'b0; reg_re_o <= 1'b0;
        end else begin
            reg_we_o <= 1'b0;
            reg_re_o <= 1'b0;
            if (!cs_act) begin
                dir_q <= DIR_WRITE; fmt_q <= ADDR_LONG; hdr_cnt <= '0;
                bit_idx <= '0; in_data <= 1'b0; reg_addr_o <= '0;
            end else begin
                if (reg_we_o) reg_addr_o <= reg_addr_o + 1'b1;
                if (clk_rise && !in_data) begin
                    hdr_cnt <= hdr_next;
                    if (hdr_next == CNT_W'(1)) dir_q <= xfer_dir_e'(mosi_s);
                    if (hdr_next == CNT_W'(2)) fmt_q <= addr_fmt_e'(mosi_s);
                    if (hdr_next >= CNT_W'(3) && hdr_next <= CNT_W'(HDR_SHORT))
                        reg_addr_o <= {reg_addr_o[ADDR_W-2:0], mosi_s};
                    if (hdr_next == hdr_len) begin
                        in_data  <= 1'b1;
                        bit_idx  <= '0;
                        reg_re_o <= (dir_q == DIR_READ);
                    end
                end else if (clk_rise) begin
                    rx_sr <= {rx_sr[DATA_W-3:0], mosi_s};
                    if (bit_idx == BIT_W'(DATA_W-1)) begin
                        bit_idx <= '0;
                        if (dir_q == DIR_READ) begin
                            reg_addr_o <= reg_addr_o + 1'b1;
                            reg_re_o   <= 1'b1;
                        end else begin
                            reg_we_o    <= 1'b1;
                            reg_wdata_o <= {rx_sr, mosi_s};
                        end
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
            end
        end
    end

    assign hdr_cnt_o = hdr_cnt;
    assign in_data_o = in_data;
    assign is_read_o = (dir_q == DIR_READ);
endmodule

// File: rtl/spi_rs_tx.sv
// Module: output shifter for the status preamble and read data, with enables.
// Assumes: STAT_W is less than the one-byte header length; rd_load and falling edges never share a cycle.
module spi_rs_tx #(
    parameter int DATA_W = 8,
    parameter int STAT_W = 6,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_start,
    input  logic              clk_fall,
    input  logic              cfg_3wire,
    input  logic              cfg_status,
    input  logic [STAT_W-1:0] status_i,
    input  logic [CNT_W-1:0]  hdr_cnt,
    input  logic              in_data,
    input  logic              is_read,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_data,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              sio_o,
    output logic              sio_oe_o
);
    logic [STAT_W-1:0] stat_sr;
    logic [DATA_W-1:0] tx_sr;
    logic              out_bit, stat_drv, rd_drv, tw_q;

    // Purpose: load, shift and release the serial output at falling clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_sr <= '0; tx_sr <= '0; out_bit <= 1'b0;
            stat_drv <= 1'b0; rd_drv <= 1'b0; tw_q <= 1'b0;
        end else if (!cs_act) begin
            stat_drv <= 1'b0;
            rd_drv   <= 1'b0;
            out_bit  <= 1'b0;
        end else begin
            if (cs_start) begin
                tw_q     <= cfg_3wire;
                stat_sr  <= status_i;
                stat_drv <= cfg_status & ~cfg_3wire;
                out_bit  <= cfg_status & ~cfg_3wire & status_i[STAT_W-1];
            end
            if (rd_load) tx_sr <= rd_data;
            if (clk_fall) begin
                if (in_data && is_read) begin
                    out_bit <= tx_sr[DATA_W-1];
                    tx_sr   <= tx_sr << 1;
                    rd_drv  <= 1'b1;
                end else if (stat_drv && hdr_cnt != '0) begin
                    if (hdr_cnt < CNT_W'(STAT_W)) begin
                        out_bit <= stat_sr[STAT_W-2];
                        stat_sr <= stat_sr << 1;
                    end else begin
                        stat_drv <= 1'b0;
                        out_bit  <= 1'b0;
                    end
                end
            end
        end
    end

    assign miso_o    = out_bit;
    assign miso_oe_o = stat_drv | (rd_drv & ~tw_q);
    assign sio_o     = out_bit;
    assign sio_oe_o  = rd_drv & tw_q;
endmodule

// File: rtl/spi_regslave.sv
// Module: SPI slave for a register file, sampled in the system clock domain.
// Assumes: serial clock high and low phases each last at least four clk cycles;
//          reg_rdata_i is valid combinationally in the cycle reg_re_o is high.
module spi_regslave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int STAT_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n_i,
    input  logic              spi_clk_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    output logic              spi_miso_oe_o,
    output logic              sio_o,
    output logic              sio_oe_o,
    input  logic              cfg_3wire_i,
    input  logic              cfg_status_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int HDR_LONG = 2 + ADDR_W + DATA_W;
    localparam int CNT_W    = $clog2(HDR_LONG + 1);

    logic cs_s, clk_s, mosi_s, cs_d, clk_d;
    logic cs_act, cs_start, clk_rise, clk_fall;
    logic [CNT_W-1:0] hdr_cnt;
    logic in_data, is_read;

    spi_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d_i(spi_cs_n_i), .q_o(cs_s));
    spi_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d_i(spi_clk_i), .q_o(clk_s));
    spi_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .d_i(spi_mosi_i), .q_o(mosi_s));

    // Purpose: hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            clk_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            clk_d <= clk_s;
        end
    end

    assign cs_act   = ~cs_s;
    assign cs_start = cs_d & ~cs_s;
    assign clk_rise = clk_s & ~clk_d;
    assign clk_fall = ~clk_s & clk_d;

    spi_rs_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .clk_rise(clk_rise), .mosi_s(mosi_s),
        .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o),
        .reg_re_o(reg_re_o), .hdr_cnt_o(hdr_cnt), .in_data_o(in_data), .is_read_o(is_read));

    spi_rs_tx #(.DATA_W(DATA_W), .STAT_W(STAT_W), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_start(cs_start), .clk_fall(clk_fall),
        .cfg_3wire(cfg_3wire_i), .cfg_status(cfg_status_i), .status_i(status_i),
        .hdr_cnt(hdr_cnt), .in_data(in_data), .is_read(is_read), .rd_load(reg_re_o),
        .rd_data(reg_rdata_i), .miso_o(spi_miso_o), .miso_oe_o(spi_miso_oe_o),
        .sio_o(sio_o), .sio_oe_o(sio_oe_o));
endmodule

// File: rtl/spi_rs_checker.sv
// Module: protocol assertions for spi_regslave, attached with bind.
// Assumes: the synchronous active-low reset of the bound block.
module spi_rs_checker #(
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n_i,
    input logic              cs_act,
    input logic              reg_we_o,
    input logic              reg_re_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic              spi_miso_oe_o,
    input logic              sio_oe_o
);
    localparam int LIM = SYNC_STAGES + 1;
    logic [7:0] idle_cnt;

    // Purpose: count consecutive cycles with chip select high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          idle_cnt <= '0;
        else if (!spi_cs_n_i) idle_cnt <= '0;
        else if (idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 1'b1;
    end

    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);
    a_r4_we_re_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_o && reg_re_o));
    a_r6_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re_o |=> !reg_re_o);
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o && cs_act) |=> (!cs_act || reg_addr_o == $past(reg_addr_o) + 1'b1));
    a_r8_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(spi_miso_oe_o && sio_oe_o));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt >= 8'(LIM)) |-> (!spi_miso_oe_o && !sio_oe_o));
endmodule

bind spi_regslave spi_rs_checker #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_spi_rs_checker (
    .clk(clk), .rst_n(rst_n), .spi_cs_n_i(spi_cs_n_i), .cs_act(cs_act),
    .reg_we_o(reg_we_o), .reg_re_o(reg_re_o), .reg_addr_o(reg_addr_o),
    .spi_miso_oe_o(spi_miso_oe_o), .sio_oe_o(sio_oe_o));

// File: tb/spi_regslave_bench.sv
module spi_regslave_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, cfg_3w = 1'b0, cfg_st = 1'b0;
    logic [5:0] status = '0;
    logic miso, miso_oe, sio, sio_oe, reg_we, reg_re;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [0:63];
    logic [7:0] exp_mem [0:63];
    logic [13:0] wq[$];
    logic ob_m[$], ob_moe[$], ob_s[$], ob_soe[$];
    int n_cmp = 0, n_bad = 0, re_cnt = 0, idle = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_regslave u_spi_regslave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n_i(cs_n), .spi_clk_i(sclk), .spi_mosi_i(mosi),
        .spi_miso_o(miso), .spi_miso_oe_o(miso_oe), .sio_o(sio), .sio_oe_o(sio_oe),
        .cfg_3wire_i(cfg_3w), .cfg_status_i(cfg_st), .status_i(status),
        .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
        .reg_re_o(reg_re), .reg_rdata_i(reg_rdata));

    function automatic logic [7:0] seed(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // register file environment and write/read strobe monitor
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= seed(i);
        end else begin
            if (reg_we) begin
                mem[reg_addr] <= reg_wdata;
                wq.push_back({reg_addr, reg_wdata});
            end
            if (reg_re) re_cnt++;
        end
    end

    task automatic check(string r, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // R9: outputs quiet once chip select has been high long enough, every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cs_n) idle++; else idle = 0;
            if (idle >= 6) check("R9 idle enables", {miso_oe, sio_oe}, 2'b00);
        end
    end

    task automatic xfer(input bit rd, input bit shrt, input logic [5:0] a, input int nb,
                        input logic [7:0] w0, input logic [7:0] w1, input logic [7:0] w2,
                        input int extra);
        bit q[$];
        logic [7:0] wb;
        q.push_back(rd); q.push_back(shrt);
        for (int i = 5; i >= 0; i--) q.push_back(a[i]);
        if (!shrt) for (int i = 0; i < 8; i++) q.push_back(1'b0);
        for (int k = 0; k < nb; k++) begin
            wb = (k == 0) ? w0 : (k == 1) ? w1 : w2;
            if (rd) wb = 8'h00;
            for (int i = 7; i >= 0; i--) q.push_back(wb[i]);
        end
        for (int i = 0; i < extra; i++) q.push_back(1'b1);
        ob_m.delete(); ob_moe.delete(); ob_s.delete(); ob_soe.delete();
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        foreach (q[i]) begin
            mosi = q[i];
            repeat (8) @(negedge clk);
            ob_m.push_back(miso); ob_moe.push_back(miso_oe);
            ob_s.push_back(sio);  ob_soe.push_back(sio_oe);
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        mosi = 1'b0;
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [7:0] got_byte(int st, bit three);
        logic [7:0] v = '0;
        for (int i = 0; i < 8; i++) v = {v[6:0], three ? ob_s[st+i] : ob_m[st+i]};
        return v;
    endfunction

    function automatic int ones(int st, int n, bit three);
        int c = 0;
        for (int i = st; i < st + n; i++) c += int'(three ? ob_soe[i] : ob_moe[i]);
        return c;
    endfunction

    function automatic logic [13:0] wq_at(int i);
        return (i < wq.size()) ? wq[i] : 14'h3FFF;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) exp_mem[i] = seed(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // reset state (R9, R4)
        check("R9 reset enables", {miso_oe, sio_oe}, 2'b00);
        check("R4 reset strobes", {reg_we, reg_re}, 2'b00);

        // R1/R4: one-byte header single write; R9 no drive during write
        wq.delete();
        xfer(1'b0, 1'b1, 6'h05, 1, 8'hA6, 8'h00, 8'h00, 0);
        exp_mem[5] = 8'hA6;
        check("R1 R4 write count", wq.size(), 1);
        check("R4 write entry", wq_at(0), {6'h05, 8'hA6});
        check("R9 write quiet", ones(0, 16, 1'b0) + ones(0, 16, 1'b1), 0);

        // R3/R6: single read, data taken at rising edges MSB first
        re_cnt = 0;
        xfer(1'b1, 1'b1, 6'h05, 1, 8'h00, 8'h00, 8'h00, 0);
        check("R3 R6 read byte", got_byte(8, 1'b0), exp_mem[5]);
        check("R6 read drive", ones(8, 8, 1'b0), 8);
        check("R6 read strobes", re_cnt, 2);
        check("R9 header quiet", ones(0, 8, 1'b0), 0);

        // R5: burst write across the wrap point
        wq.delete();
        xfer(1'b0, 1'b1, 6'h3E, 3, 8'h11, 8'h22, 8'h33, 0);
        exp_mem[62] = 8'h11; exp_mem[63] = 8'h22; exp_mem[0] = 8'h33;
        check("R5 burst count", wq.size(), 3);
        check("R5 burst 0", wq_at(0), {6'h3E, 8'h11});
        check("R5 burst 1", wq_at(1), {6'h3F, 8'h22});
        check("R5 burst wrap", wq_at(2), {6'h00, 8'h33});

        // R5: burst read across the wrap point
        xfer(1'b1, 1'b1, 6'h3E, 3, 8'h00, 8'h00, 8'h00, 0);
        check("R5 R3 burst read 0", got_byte(8, 1'b0), exp_mem[62]);
        check("R5 R3 burst read 1", got_byte(16, 1'b0), exp_mem[63]);
        check("R5 R3 burst read 2", got_byte(24, 1'b0), exp_mem[0]);

        // R2: two-byte header write and read
        wq.delete();
        xfer(1'b0, 1'b0, 6'h12, 1, 8'h5C, 8'h00, 8'h00, 0);
        exp_mem[18] = 8'h5C;
        check("R2 long write", wq_at(0), {6'h12, 8'h5C});
        check("R2 long write count", wq.size(), 1);
        xfer(1'b1, 1'b0, 6'h12, 1, 8'h00, 8'h00, 8'h00, 0);
        check("R2 long read byte", got_byte(16, 1'b0), exp_mem[18]);
        check("R2 padding quiet", ones(8, 8, 1'b0), 0);

        // R7: status preamble on a read and on a write
        cfg_st = 1'b1; status = 6'b101101;
        xfer(1'b1, 1'b1, 6'h3F, 1, 8'h00, 8'h00, 8'h00, 0);
        check("R7 status bits", {ob_m[0], ob_m[1], ob_m[2], ob_m[3], ob_m[4], ob_m[5]}, 6'b101101);
        check("R7 status driven", ones(0, 6, 1'b0), 6);
        check("R7 status released", ones(6, 2, 1'b0), 0);
        check("R7 data after status", got_byte(8, 1'b0), exp_mem[63]);
        status = 6'b010011;
        wq.delete();
        xfer(1'b0, 1'b1, 6'h20, 1, 8'h9E, 8'h00, 8'h00, 0);
        exp_mem[32] = 8'h9E;
        check("R7 status on write", {ob_m[0], ob_m[1], ob_m[2], ob_m[3], ob_m[4], ob_m[5]}, 6'b010011);
        check("R7 write after status quiet", ones(6, 10, 1'b0), 0);

        // R8: 3-wire read on the shared line, status suppressed
        cfg_3w = 1'b1;
        xfer(1'b1, 1'b1, 6'h00, 1, 8'h00, 8'h00, 8'h00, 0);
        check("R8 output line quiet", ones(0, 16, 1'b0), 0);
        check("R8 shared drive", ones(8, 8, 1'b1), 8);
        check("R8 shared header quiet", ones(0, 8, 1'b1), 0);
        check("R8 shared byte", got_byte(8, 1'b1), exp_mem[0]);
        cfg_3w = 1'b0; cfg_st = 1'b0;

        // R10: partial trailing byte discarded
        wq.delete();
        xfer(1'b0, 1'b1, 6'h07, 1, 8'hC4, 8'h00, 8'h00, 5);
        exp_mem[7] = 8'hC4;
        check("R10 only full byte written", wq.size(), 1);
        check("R10 full byte", wq_at(0), {6'h07, 8'hC4});
        xfer(1'b1, 1'b1, 6'h08, 1, 8'h00, 8'h00, 8'h00, 0);
        check("R10 next address untouched", got_byte(8, 1'b0), exp_mem[8]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule